// File: doc/BRIEF.md
# Lock-Aware Glitch-Free PLL Bypass Selector

This block sits right after a PLL and decides which clock reaches the downstream tree: the PLL reference clock, the PLL output clock, or no clock at all. The choice comes from a 2-bit mode, the PLL lock indicator and a master enable. Some modes follow the lock indicator and others ignore it. One mode holds the output silent whenever the PLL is unlocked, so a clock supervisor downstream never sees a wrong frequency.

Every switch is break-before-make. The controller, clocked by the reference clock, first withdraws the request for the old source. Each source's gate re-times that request through a synchronizer in its own clock domain and opens or closes only while its clock is low. The gate's state is synchronized back to the controller, and only after the old gate is seen closed is the new one requested. The active-source status reads none for the whole transition.

When the enable falls, the mux is first moved to the source that the mode assigns to a disabled PLL. Only then is the PLL run request withdrawn. Both source clocks must keep running until a transition has completed. There is no data stream, so all pins are plain control and status signals with no valid/ready handshake.

Top module: `pll_src_sel`

## Requirements
- R1: The mode encoding is 0 automatic, 1 locked-only, 2 force reference, 3 force PLL, and the `active_src` encoding is 0 none, 1 reference, 2 PLL. In mode 0 with enable high, the output follows the PLL clock while lock is high (status 2) and the reference clock while lock is low (status 1).
- R2: In mode 0 with enable low, the output follows the reference clock whatever the lock level is (status 1).
- R3: In mode 1 with enable high, the output follows the PLL clock while locked. While unlocked, the output is held low with no edges (status 0).
- R4: In mode 1 with enable low, no clock is produced (status 0, output low).
- R5: In mode 2, the output follows the reference clock regardless of lock and enable (status 1).
- R6: In mode 3 with enable high, the output follows the PLL clock regardless of lock (status 2). With enable low, no clock is produced.
- R7: Switching is glitch-free. No high or low phase of `clk_out` is shorter than the shorter source half-period, and the two source gates are never open at the same time.
- R8: `pll_run` is high whenever the synchronized enable is high. After enable falls, `pll_run` falls only once the PLL gate is closed and the status no longer reads 2.
- R9: The status reads 0 during every transition between two sources. A settled source is shown only after its gate is confirmed open.
- R10: During reset, `clk_out`, `active_src` and `pll_run` are all 0. After reset, the reference path is opened through the handshake whenever the mode calls for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | PLL reference clock; also clocks the controller |
| pll_clk | input | 1 | PLL output clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Source selection mode (encoding in R1) |
| enable | input | 1 | PLL master enable, asynchronous |
| lock | input | 1 | PLL lock indicator, asynchronous |
| clk_out | output | 1 | Selected, gated clock |
| pll_run | output | 1 | Request to keep the PLL running |
| active_src | output | 2 | Settled source: 0 none, 1 reference, 2 PLL |

## Verification
The hardest situation to reach is a lock or mode change that lands while a handshake is already in flight, with the two clocks at unrelated phases. That is where a runt pulse or two open gates would appear. The stimulus uses periods of 10 ns and 7.3 ns, which share no simple ratio. It toggles lock and mode after pseudo-random delays that are often shorter than one handshake. A continuous monitor times every output phase, and a separate monitor checks the status at each fall of `pll_run`.

// File: rtl/pll_src_sel_pkg.sv
`timescale 1ns/1ps
package pll_src_sel_pkg;
  localparam int NUM_SRC = 2;  // gate index 0 = reference, 1 = PLL
  localparam int IDX_REF = 0;
  localparam int IDX_PLL = 1;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_REF  = 2'd1,
    SRC_PLL  = 2'd2
  } src_e;

  typedef enum logic [1:0] {
    MODE_AUTO      = 2'd0,
    MODE_LOCK_ONLY = 2'd1,
    MODE_FORCE_REF = 2'd2,
    MODE_FORCE_PLL = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ST_STEADY = 2'd0,
    ST_DROP   = 2'd1,
    ST_RAISE  = 2'd2
  } hs_state_e;
endpackage

// File: rtl/bit_sync.sv
`timescale 1ns/1ps
module bit_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/clk_gate_cell.sv
`timescale 1ns/1ps
module clk_gate_cell #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic gclk,
  output logic en
);
  logic req_s;

  bit_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d(req), .q(req_s)
  );

  // enable changes only while the clock is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en <= 1'b0;
    else        en <= req_s;
  end

  assign gclk = clk & en;
endmodule

// File: rtl/sel_ctrl.sv
`timescale 1ns/1ps
module sel_ctrl
  import pll_src_sel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode,
  input  logic               enable,
  input  logic               lock,
  input  logic [NUM_SRC-1:0] ack,
  output logic [NUM_SRC-1:0] req,
  output src_e               status,
  output logic               pll_run
);
  localparam int IN_W = 4;

  logic [IN_W-1:0] in_s;
  logic [1:0]      mode_s, mode_prev;
  logic            en_s, lock_s;
  mode_e           mode_use;
  src_e            tgt, cur_q, nxt_q;
  hs_state_e       st_q;
  logic [NUM_SRC-1:0] req_q;
  logic            run_q;

  bit_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk(clk), .rst_n(rst_n), .d({mode, lock, enable}), .q(in_s)
  );
  assign mode_s = in_s[3:2];
  assign lock_s = in_s[1];
  assign en_s   = in_s[0];

  function automatic logic [NUM_SRC-1:0] req_bits(input src_e s);
    logic [NUM_SRC-1:0] r;
    r = '0;
    if (s == SRC_REF) r[IDX_REF] = 1'b1;
    if (s == SRC_PLL) r[IDX_PLL] = 1'b1;
    return r;
  endfunction

  function automatic logic ack_of(input src_e s, input logic [NUM_SRC-1:0] a);
    if (s == SRC_REF) return a[IDX_REF];
    if (s == SRC_PLL) return a[IDX_PLL];
    return 1'b0;
  endfunction

  always_comb begin
    case (mode_use)
      MODE_AUTO:      tgt = (en_s && lock_s) ? SRC_PLL : SRC_REF;
      MODE_LOCK_ONLY: tgt = (en_s && lock_s) ? SRC_PLL : SRC_NONE;
      MODE_FORCE_REF: tgt = SRC_REF;
      default:        tgt = en_s ? SRC_PLL : SRC_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_prev <= 2'd0;
      mode_use  <= MODE_AUTO;
      st_q      <= ST_STEADY;
      cur_q     <= SRC_NONE;
      nxt_q     <= SRC_NONE;
      req_q     <= '0;
      run_q     <= 1'b0;
    end else begin
      // accept a mode only after two equal synchronized samples
      mode_prev <= mode_s;
      if (mode_s == mode_prev) mode_use <= mode_e'(mode_s);

      case (st_q)
        ST_STEADY: begin
          if (tgt != cur_q) begin
            nxt_q <= tgt;
            if (cur_q == SRC_NONE) begin
              req_q <= req_bits(tgt);
              st_q  <= ST_RAISE;
            end else begin
              req_q <= '0;
              st_q  <= ST_DROP;
            end
          end
        end
        ST_DROP: begin
          if (!ack_of(cur_q, ack)) begin
            cur_q <= SRC_NONE;
            if (tgt == SRC_NONE) begin
              st_q <= ST_STEADY;
            end else begin
              nxt_q <= tgt;
              req_q <= req_bits(tgt);
              st_q  <= ST_RAISE;
            end
          end
        end
        default: begin
          if (ack_of(nxt_q, ack)) begin
            cur_q <= nxt_q;
            st_q  <= ST_STEADY;
          end
        end
      endcase

      if (en_s)                                        run_q <= 1'b1;
      else if (st_q == ST_STEADY && cur_q != SRC_PLL)  run_q <= 1'b0;
    end
  end

  assign req     = req_q;
  assign status  = (st_q == ST_STEADY) ? cur_q : SRC_NONE;
  assign pll_run = run_q;
endmodule

// File: rtl/pll_src_sel.sv
`timescale 1ns/1ps
module pll_src_sel
  import pll_src_sel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       ref_clk,
  input  logic       pll_clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       enable,
  input  logic       lock,
  output logic       clk_out,
  output logic       pll_run,
  output logic [1:0] active_src
);
  logic [NUM_SRC-1:0] src_clk, gate_req, gate_en, gate_ack, gclk;
  src_e               status;

  assign src_clk[IDX_REF] = ref_clk;
  assign src_clk[IDX_PLL] = pll_clk;

  sel_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(ref_clk), .rst_n(rst_n), .mode(mode), .enable(enable), .lock(lock),
    .ack(gate_ack), .req(gate_req), .status(status), .pll_run(pll_run)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    clk_gate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
      .clk(src_clk[i]), .rst_n(rst_n), .req(gate_req[i]),
      .gclk(gclk[i]), .en(gate_en[i])
    );
    bit_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_ack_sync (
      .clk(ref_clk), .rst_n(rst_n), .d(gate_en[i]), .q(gate_ack[i])
    );
  end

  assign clk_out    = |gclk;
  assign active_src = status;
endmodule

// File: rtl/pll_src_sel_chk.sv
`timescale 1ns/1ps
module pll_src_sel_chk
  import pll_src_sel_pkg::*;
(
  input logic               ref_clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] gate_en,
  input logic [NUM_SRC-1:0] gate_ack,
  input logic [1:0]         active_src,
  input logic               pll_run
);
  AST_GATES_EXCLUSIVE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $countones(gate_en) <= 1); // R7

  AST_PLL_STATUS_BACKED: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (active_src == SRC_PLL) |-> (gate_ack[IDX_PLL] && pll_run)); // R1

  AST_REF_STATUS_BACKED: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (active_src == SRC_REF) |-> gate_ack[IDX_REF]); // R5

  AST_RUN_DROP_ORDER: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $fell(pll_run) |-> (!gate_ack[IDX_PLL] && active_src != SRC_PLL)); // R8

  AST_STATUS_LEGAL: assert property (@(posedge ref_clk) disable iff (!rst_n)
    active_src != 2'd3); // R9
endmodule

bind pll_src_sel pll_src_sel_chk chk_i (
  .ref_clk(ref_clk), .rst_n(rst_n), .gate_en(gate_en), .gate_ack(gate_ack),
  .active_src(active_src), .pll_run(pll_run)
);

// File: tb/pll_src_sel_tb_top.sv
`timescale 1ns/1ps
module pll_src_sel_tb_top;
  localparam real REF_PERIOD = 10.0;
  localparam real PLL_PERIOD = 7.3;
  localparam real MIN_PHASE  = PLL_PERIOD / 2.0 - 0.01;
  localparam int  SETTLE     = 60;

  typedef struct {
    logic [1:0] exp_src;
    logic       exp_run;
    string      tag;
  } item_t;

  logic ref_clk = 1'b0, pll_clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic enable = 1'b0, lock = 1'b0;
  logic clk_out, pll_run;
  logic [1:0] active_src;

  int checks = 0, failures = 0, glitches = 0, fall_checks = 0;
  item_t sb_q[$];
  bit mon_busy = 0;
  logic [1:0] last_status = 2'd0;
  realtime last_edge = 0.0;
  bit finished = 0;

  always #(REF_PERIOD/2.0) ref_clk = ~ref_clk;
  always #(PLL_PERIOD/2.0) pll_clk = ~pll_clk;

  pll_src_sel dut_i (
    .ref_clk(ref_clk), .pll_clk(pll_clk), .rst_n(rst_n), .mode(mode),
    .enable(enable), .lock(lock), .clk_out(clk_out), .pll_run(pll_run),
    .active_src(active_src)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R7: every output phase at least the shorter source half-period
  always @(clk_out) begin
    if (rst_n && last_edge > 0.0 && ($realtime - last_edge) < MIN_PHASE) glitches++;
    last_edge = $realtime;
  end

  always @(negedge ref_clk) last_status = active_src;

  // R8: pll_run falls only once the status has left the PLL
  always @(negedge pll_run) begin
    if (rst_n) begin
      fall_checks++;
      chk(last_status != 2'd2, "R8 status at pll_run fall", last_status, 0);
    end
  end

  task automatic check_clk(input logic [1:0] src, input string tag);
    int bad = 0;
    if (src == 2'd1) begin
      for (int k = 0; k < 4; k++) begin
        @(posedge ref_clk); #1; if (clk_out !== 1'b1) bad++;
        @(negedge ref_clk); #1; if (clk_out !== 1'b0) bad++;
      end
    end else if (src == 2'd2) begin
      for (int k = 0; k < 4; k++) begin
        @(posedge pll_clk); #1; if (clk_out !== 1'b1) bad++;
        @(negedge pll_clk); #1; if (clk_out !== 1'b0) bad++;
      end
    end else begin
      for (int k = 0; k < 20; k++) begin
        #0.9; if (clk_out !== 1'b0) bad++;
      end
    end
    chk(bad == 0, {tag, " clk_out waveform"}, bad, 0);
  endtask

  // monitor: pops expected items and compares once settled
  initial begin
    forever begin
      item_t it;
      logic [1:0] prev;
      bit saw_none;
      wait (sb_q.size() > 0);
      mon_busy = 1;
      it = sb_q.pop_front();
      prev = active_src;
      saw_none = 0;
      repeat (SETTLE) begin
        @(negedge ref_clk);
        if (active_src == 2'd0) saw_none = 1;
      end
      chk(active_src == it.exp_src, {it.tag, " active_src"}, active_src, it.exp_src);
      chk(pll_run == it.exp_run, {it.tag, " pll_run"}, pll_run, it.exp_run);
      check_clk(it.exp_src, it.tag);
      if (prev != 2'd0 && it.exp_src != 2'd0 && prev != it.exp_src)
        chk(saw_none, "R9 status none during transition", saw_none, 1);
      mon_busy = 0;
    end
  end

  task automatic apply(input logic [1:0] m, input logic e, input logic l,
                       input logic [1:0] src, input logic run, input string tag);
    item_t it;
    @(negedge ref_clk);
    mode = m; enable = e; lock = l;
    it.exp_src = src; it.exp_run = run; it.tag = tag;
    sb_q.push_back(it);
    #1;
    wait (sb_q.size() == 0 && !mon_busy);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(REF_PERIOD * 150000.0);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (5) @(negedge ref_clk);
    chk(clk_out == 1'b0, "R10 clk_out in reset", clk_out, 0);
    chk(active_src == 2'd0, "R10 status in reset", active_src, 0);
    chk(pll_run == 1'b0, "R10 pll_run in reset", pll_run, 0);
    rst_n = 1'b1;

    apply(2'd0, 1'b0, 1'b0, 2'd1, 1'b0, "R10 reference after reset");
    apply(2'd0, 1'b1, 1'b1, 2'd2, 1'b1, "R1 auto locked");
    apply(2'd0, 1'b1, 1'b0, 2'd1, 1'b1, "R1 auto unlocked");
    apply(2'd0, 1'b0, 1'b1, 2'd1, 1'b0, "R2 auto disabled");
    apply(2'd1, 1'b1, 1'b1, 2'd2, 1'b1, "R3 locked-only locked");
    apply(2'd1, 1'b1, 1'b0, 2'd0, 1'b1, "R3 locked-only unlocked");
    apply(2'd1, 1'b1, 1'b1, 2'd2, 1'b1, "R3 locked-only relock");
    apply(2'd1, 1'b0, 1'b1, 2'd0, 1'b0, "R4 locked-only disabled");
    apply(2'd2, 1'b1, 1'b1, 2'd1, 1'b1, "R5 force ref locked");
    apply(2'd2, 1'b1, 1'b0, 2'd1, 1'b1, "R5 force ref unlocked");
    apply(2'd2, 1'b0, 1'b1, 2'd1, 1'b0, "R5 force ref disabled");
    apply(2'd3, 1'b1, 1'b0, 2'd2, 1'b1, "R6 force pll unlocked");
    apply(2'd3, 1'b0, 1'b0, 2'd0, 1'b0, "R6 force pll disabled");
    apply(2'd3, 1'b1, 1'b1, 2'd2, 1'b1, "R6 force pll enabled");
    apply(2'd2, 1'b1, 1'b1, 2'd1, 1'b1, "R9 pll to ref");
    apply(2'd0, 1'b1, 1'b1, 2'd2, 1'b1, "R9 ref to pll");

    // R7 stress: lock and mode change at pseudo-random times
    for (int n = 0; n < 60; n++) begin
      #($urandom_range(3, 90));
      lock = ~lock;
      if ((n % 3) == 0) mode = 2'($urandom_range(0, 3));
    end
    apply(2'd0, 1'b1, 1'b1, 2'd2, 1'b1, "R7 settle after stress");

    chk(glitches == 0, "R7 short clk_out phases", glitches, 0);
    chk(fall_checks > 0, "R8 pll_run falls observed", fall_checks, 1);
    finish_run();
  end
endmodule